// File: doc/BRIEF.md
# Three-Decade Decimal Event Counter with Holding Latches

The block counts pulses on a slow, asynchronous count input across three cascaded decimal decades: units, tens and hundreds. The full range is 000 to 999. The design is fully synchronous to a system clock. The count input passes through a two-stage synchronizer, and each detected falling edge advances the count by one. A disable pin gates counting without losing the present value. An active-high master-clear pin returns all decades to zero.

Each decade feeds a four-bit holding register, and the held digits form the output bus. While the hold pin is low, these registers follow the live count one system clock behind. While the hold pin is high, they keep their value, even through a master clear. This lets a reading be frozen and read at leisure while counting continues underneath.

An overflow strobe marks each wrap from 999 to 000, so several blocks can be chained. The block has no streaming data path, so every pin is a plain level or strobe and none of them applies back-pressure.

Top module: `decade_tally3`

## Requirements
- R1: The live count advances by exactly one for each falling edge of `cnt_in`. A rising edge or a steady level has no effect. `held_bcd` carries units in bits [3:0], tens in [7:4] and hundreds in [11:8], each as active-high BCD.
- R2: Carries ripple decimally. Tens advances when units goes from 9 to 0, and hundreds advances when tens and units both wrap. Every digit stays in the range 0..9.
- R3: While `mr` is high at a rising clock edge, all three decades become zero at that edge. The system reset `rst_n` (active low) clears the decades, the holding registers and `ovf`.
- R4: While `dis` is high, falling edges of `cnt_in` are ignored and the live count keeps its value.
- R5: While `hold` is high, `held_bcd` does not change, whatever the other inputs do.
- R6: If `hold` stays high for the whole of a master clear, `held_bcd` still shows the count from before the clear. Dropping `hold` afterwards shows zero.
- R7: `ovf` is high for exactly one clock cycle on the edge where the count goes from 999 to 000. This gives one pulse per 1000 counts, and the live count reads 000 while `ovf` is high.
- R8: With `hold` low, a falling edge of `cnt_in` applied before rising clock edge k first appears on `held_bcd` after edge k+3. The cycle after edge k+2 still shows the old value.
- R9: `mr` takes priority over counting. A falling edge that arrives while `mr` is high leaves the count at zero and raises no `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cnt_in | input | 1 | Asynchronous count input; falling edges count |
| dis | input | 1 | Count gate, high blocks counting |
| mr | input | 1 | Master clear of the decades, active high |
| hold | input | 1 | High freezes the holding registers |
| held_bcd | output | 4*NUM_DIGITS | Held digits, units lowest nibble |
| ovf | output | 1 | One-cycle strobe on wrap past the top count |

## Verification
A corrupted decade shows on `held_bcd` one clock after the bad edge when `hold` is low. A digit above 9 or a missed carry is visible from that cycle onward. A bad carry term shows up at the next decade boundary: at 10, at 100, or at 999 rolling to 000, where `ovf` either fails to appear or lasts more than one cycle. A holding register that leaks through is seen on the first count or clear while `hold` is high.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;

  // true when every nibble of a packed digit bus is a legal decimal digit
  function automatic logic all_decimal(input logic [63:0] bus, input int ndig);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ndig; i++) begin
      if (bus[i*BCD_W +: BCD_W] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/tally_edge_sync.sv
module tally_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  // stages 0..LAST synchronize; stage SYNC_STAGES is the prior sample
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], din};
  end

  assign fall_o = pipe_q[SYNC_STAGES] & ~pipe_q[LAST];
endmodule

// File: rtl/tally_decade.sv
module tally_decade
  import tally_pkg::*;
#(
  parameter int RADIX = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output bcd_t digit_o,
  output logic at_top_o
);
  localparam bcd_t TOP = bcd_t'(RADIX - 1);

  bcd_t digit_q;

  assign at_top_o = (digit_q == TOP);
  assign digit_o  = digit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      digit_q <= '0;
    else if (clr_i)  digit_q <= '0;
    else if (step_i) digit_q <= at_top_o ? '0 : digit_q + bcd_t'(1);
  end
endmodule

// File: rtl/tally_hold.sv
module tally_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= '0;
    else if (!hold_i) q_o <= d_i;
  end
endmodule

// File: rtl/decade_tally3.sv
module decade_tally3
  import tally_pkg::*;
#(
  parameter int NUM_DIGITS  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RADIX       = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cnt_in,
  input  logic                        dis,
  input  logic                        mr,
  input  logic                        hold,
  output logic [NUM_DIGITS*BCD_W-1:0] held_bcd,
  output logic                        ovf
);
  localparam int BUS_W = NUM_DIGITS * BCD_W;

  logic                  fall_w;
  logic                  cnt_en;
  logic [NUM_DIGITS-1:0] at_top_w;
  logic [NUM_DIGITS-1:0] step_w;
  logic [BUS_W-1:0]      live_bcd;
  logic                  wrap_w;

  tally_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_in), .fall_o(fall_w)
  );

  // master clear wins; disable blocks the detected edge
  assign cnt_en = fall_w & ~dis & ~mr;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DIGITS; gi++) begin : g_dec
      if (gi == 0) begin : g_lsd
        assign step_w[gi] = cnt_en;
      end else begin : g_upper
        // advance when every lower decade is at its top value
        assign step_w[gi] = cnt_en & (&at_top_w[gi-1:0]);
      end

      tally_decade #(.RADIX(RADIX)) u_dec (
        .clk(clk), .rst_n(rst_n), .clr_i(mr), .step_i(step_w[gi]),
        .digit_o(live_bcd[gi*BCD_W +: BCD_W]), .at_top_o(at_top_w[gi])
      );

      tally_hold #(.W(BCD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .hold_i(hold),
        .d_i(live_bcd[gi*BCD_W +: BCD_W]), .q_o(held_bcd[gi*BCD_W +: BCD_W])
      );
    end
  endgenerate

  assign wrap_w = cnt_en & (&at_top_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else        ovf <= wrap_w;
  end
endmodule

// File: rtl/decade_tally3_chk.sv
module decade_tally3_chk
  import tally_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        mr,
  input logic                        dis,
  input logic                        hold,
  input logic                        ovf,
  input logic [NUM_DIGITS*BCD_W-1:0] held_bcd,
  input logic [NUM_DIGITS*BCD_W-1:0] live_bcd
);
  localparam int BUS_W = NUM_DIGITS * BCD_W;

  assert_digits_decimal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    all_decimal(64'(live_bcd), NUM_DIGITS) && all_decimal(64'(held_bcd), NUM_DIGITS));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> (live_bcd == '0));

  assert_disable_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !mr) |=> (live_bcd == $past(live_bcd)));

  assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(held_bcd));

  assert_ovf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);

  assert_ovf_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (live_bcd == BUS_W'(0)));

  assert_follow_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (held_bcd == $past(live_bcd)));

  assert_clear_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mr |=> !ovf);
endmodule

bind decade_tally3 decade_tally3_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mr(mr), .dis(dis), .hold(hold),
  .ovf(ovf), .held_bcd(held_bcd), .live_bcd(live_bcd)
);

// File: tb/decade_tally3_tb_top.sv
module decade_tally3_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_in = 1'b0;
  logic        dis = 1'b0;
  logic        mr = 1'b0;
  logic        hold = 1'b0;
  logic [11:0] held_bcd;
  logic        ovf;

  int n_checks = 0;
  int n_fail = 0;
  int ovf_seen = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  decade_tally3 dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .dis(dis), .mr(mr),
    .hold(hold), .held_bcd(held_bcd), .ovf(ovf)
  );

  always @(negedge clk) begin
    cycles++;
    if (rst_n && ovf) ovf_seen++;
  end

  function automatic int to_int(input logic [11:0] b);
    return int'(b[3:0]) + 10 * int'(b[7:4]) + 100 * int'(b[11:8]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_in = 1'b1; idle(3);
      cnt_in = 1'b0; idle(3);
    end
    idle(2);
  endtask

  task automatic clear_count();
    mr = 1'b1; idle(1); mr = 1'b0; idle(2);
  endtask

  task automatic t_reset();
    idle(3);
    check("R3 reset held", to_int(held_bcd), 0);
    check("R3 reset ovf", int'(ovf), 0);
    rst_n = 1'b1; idle(2);
  endtask

  task automatic t_basic();
    pulse(7);
    check("R1 seven falls", to_int(held_bcd), 7);
    cnt_in = 1'b1; idle(6);
    check("R1 rising ignored", to_int(held_bcd), 7);
    cnt_in = 1'b0; idle(6);
    check("R1 falling counted", to_int(held_bcd), 8);
    pulse(2);
    check("R2 units to tens carry", to_int(held_bcd), 10);
    pulse(90);
    check("R2 tens to hundreds carry", to_int(held_bcd), 100);
  endtask

  task automatic t_disable();
    dis = 1'b1; pulse(5); dis = 1'b0;
    check("R4 disabled falls ignored", to_int(held_bcd), 100);
    pulse(1);
    check("R4 counting resumes", to_int(held_bcd), 101);
  endtask

  task automatic t_hold();
    hold = 1'b1; pulse(19);
    check("R5 held frozen while counting", to_int(held_bcd), 101);
    hold = 1'b0; idle(2);
    check("R5 release shows live", to_int(held_bcd), 120);
  endtask

  task automatic t_hold_clear();
    hold = 1'b1; idle(1);
    clear_count();
    check("R6 held survives clear", to_int(held_bcd), 120);
    hold = 1'b0; idle(2);
    check("R3 clear zeroes decades", to_int(held_bcd), 0);
  endtask

  task automatic t_priority();
    mr = 1'b1; pulse(4); mr = 1'b0; idle(2);
    check("R9 clear beats counting", to_int(held_bcd), 0);
  endtask

  task automatic t_latency();
    cnt_in = 1'b1; idle(4);
    cnt_in = 1'b0;
    for (int i = 0; i < 3; i++) @(posedge clk);
    @(negedge clk);
    check("R8 old value after edge k+2", to_int(held_bcd), 0);
    @(negedge clk);
    check("R8 new value after edge k+3", to_int(held_bcd), 1);
    idle(3);
    clear_count();
  endtask

  task automatic t_overflow();
    int base;
    base = ovf_seen;
    pulse(999);
    check("R1 top count", to_int(held_bcd), 999);
    check("R7 no ovf before wrap", ovf_seen - base, 0);
    pulse(1);
    check("R7 wrap to zero", to_int(held_bcd), 0);
    check("R7 single cycle ovf", ovf_seen - base, 1);
    pulse(1000);
    check("R7 one ovf per thousand", ovf_seen - base, 2);
    pulse(999);
    mr = 1'b1; cnt_in = 1'b1; idle(3); cnt_in = 1'b0; idle(4); mr = 1'b0; idle(2);
    check("R9 no ovf under clear", ovf_seen - base, 2);
    check("R9 count stays zero", to_int(held_bcd), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_disable();
        t_hold();
        t_hold_clear();
        t_priority();
        t_latency();
        t_overflow();
      end
      begin
        wait (cycles >= 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule